// File: doc/BRIEF.md
# SPI Controller Register Front End

This block is the bus-facing register file of an SPI master. A simple bus slave port takes 16-bit reads and writes into seven registers: control, chip-select flags, status, transmit buffer, receive buffer, baud divisor and a receive shadow. The registers occupy consecutive 4-byte slots in that order, so the slot index is the byte offset divided by four. Read data and an error flag come back one cycle after the strobe.

The status word changes as a side effect of data-buffer traffic. Which access triggers the change depends on the enable bit and on the mode field in control. In one mode, a write to the transmit buffer starts a transfer. In the other, a read of the receive buffer starts it. Three status bits can be cleared by software by writing a one to them. The status word is always driven on an output port, so an interrupt controller can watch it. The serial shifter, clocking and DMA are outside this block; they attach to this bookkeeping later.

Top module: `spi_reg_front`

## Requirements
- R1: After reset, control reads 0x0400, flags 0xFF00 and status 0x0001. The transmit buffer, receive buffer, baud and shadow registers read 0x0000.
- R2: A legal write stores the data into control (offset 0), flags (4), transmit buffer (12), receive buffer (16), baud (20) or shadow (24). A legal read returns the stored value on the cycle after the strobe, with the error flag low. Read data is 0 after writes and on cycles with no access.
- R3: An access whose size code is not 01 is invalid. The size codes are 00 for byte, 01 for halfword and 10 for word. An invalid access raises the error flag on the next cycle, returns read data 0 and changes no register.
- R4: An access whose offset is not a multiple of 4, or is above 24, is invalid. It is handled exactly as in R3.
- R5: Status (offset 8) is write-one-to-clear at bits 0 (transfer complete), 3 (transmit full) and 5 (receive full). A zero written to one of these bits leaves it unchanged. Bus writes never change any other status bit.
- R6: Control bit 14 is the enable bit and control bits [1:0] are the mode. When enable is 1 and the mode is 01, a write to the transmit buffer sets status bit 5 and clears status bit 3, in addition to storing the data.
- R7: When enable is 1 and the mode is 00, a read of the receive buffer returns the stored value and clears status bits 5 and 3.
- R8: With enable at 0 or any other mode, transmit-buffer writes and receive-buffer reads do not change status. Reads of every register other than the receive buffer never change status.
- R9: The status output always equals the current status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | Access size code (01 = 16-bit) |
| bus_addr | input | ADDR_W | Byte offset into the block |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Invalid access flag, the cycle after the access |
| status_o | output | 16 | Live status word |

## Verification
From the bus, the only way to set a status bit is through the transfer side effect. Reset sets the complete bit, and the receive-full bit is set only by a transmit-buffer write while enable is 1 and the mode is 01. The transmit-full bit can never be raised from the ports, so only its clearing paths can be exercised. Directed sequences program control into the needed mode, raise receive-full, then test clearing by write-one, by a receive read in mode 00, and the cases where nothing should clear it. Random traffic biased toward control rewrites then moves through the modes often enough to hit each side-effect path many times, checked against a bench model of the status rules.

// File: rtl/spi_reg_front.sv
module spi_reg_front #(
  parameter int ADDR_W     = 8,
  parameter int NREG       = 7,
  parameter int SLOT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_err,
  output logic [15:0]       status_o
);
  localparam int SH = $clog2(SLOT_BYTES);
  localparam int IW = ADDR_W - SH;
  localparam logic [IW-1:0] I_CTL = 0, I_FLG = 1, I_STA = 2, I_TXB = 3,
                            I_RXB = 4, I_BAU = 5, I_SHD = 6;
  localparam logic [IW-1:0] NREG_I = IW'(NREG);
  localparam int B_DONE = 0, B_TXF = 3, B_RXF = 5, B_EN = 14;
  localparam logic [15:0] W1C = 16'h0029;
  localparam logic [1:0] SZ_HALF = 2'b01, M_RXRD = 2'b00, M_TXWR = 2'b01;

  logic [15:0] ctl, flg, sta, txb, rxb, bau, shd, rmux;
  logic [IW-1:0] idx;
  logic legal, tx_go, rx_go;

  assign idx      = bus_addr[ADDR_W-1:SH];
  assign legal    = (bus_size == SZ_HALF) && (bus_addr[SH-1:0] == '0) && (idx < NREG_I);
  assign tx_go    = ctl[B_EN] && (ctl[1:0] == M_TXWR);
  assign rx_go    = ctl[B_EN] && (ctl[1:0] == M_RXRD);
  assign status_o = sta;

  always_comb begin
    case (idx)
      I_CTL:   rmux = ctl;
      I_FLG:   rmux = flg;
      I_STA:   rmux = sta;
      I_TXB:   rmux = txb;
      I_RXB:   rmux = rxb;
      I_BAU:   rmux = bau;
      I_SHD:   rmux = shd;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= 16'h0400; flg <= 16'hFF00; sta <= 16'h0001;
      txb <= '0; rxb <= '0; bau <= '0; shd <= '0;
      bus_rdata <= '0; bus_err <= 1'b0;
    end else begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      if (bus_valid) begin
        if (!legal) bus_err <= 1'b1;
        else if (bus_write) begin
          case (idx)
            I_CTL: ctl <= bus_wdata;
            I_FLG: flg <= bus_wdata;
            I_STA: sta <= sta & ~(bus_wdata & W1C);
            I_TXB: begin
              txb <= bus_wdata;
              if (tx_go) begin
                sta[B_RXF] <= 1'b1;
                sta[B_TXF] <= 1'b0;
              end
            end
            I_RXB: rxb <= bus_wdata;
            I_BAU: bau <= bus_wdata;
            I_SHD: shd <= bus_wdata;
            default: ;
          endcase
        end else begin
          bus_rdata <= rmux;
          if (idx == I_RXB && rx_go) begin
            sta[B_RXF] <= 1'b0;
            sta[B_TXF] <= 1'b0;
          end
        end
      end
    end
  end

  p_err_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_valid));
  p_bad_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !legal) |=> (bus_err && bus_rdata == 16'h0 && $stable(ctl) && $stable(sta)));
  p_fixed_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable({sta[15:6], sta[4], sta[2:1]}));
  p_tx_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && legal && idx == I_TXB && tx_go) |=> (status_o[B_RXF] && !status_o[B_TXF]));
  p_rx_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && legal && idx == I_RXB && rx_go) |=> (!status_o[B_RXF] && !status_o[B_TXF]));
  p_read_calm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && idx != I_RXB) |=> $stable(sta));
endmodule

// File: tb/tb_spi_reg_front.sv
`timescale 1ns/1ps
module tb_spi_reg_front;
  logic clk = 0, rst_n = 0, bus_valid = 0, bus_write = 0;
  logic [1:0] bus_size = 2'b01;
  logic [7:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata, status_o;
  logic bus_err;
  int n_chk = 0, n_fail = 0;
  logic [15:0] m [7];

  spi_reg_front dut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .status_o(status_o));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_legal(input logic [7:0] a, input logic [1:0] sz);
    return sz == 2'b01 && a[1:0] == 2'b00 && (a >> 2) < 7;
  endfunction

  task automatic op(input bit wr, input logic [7:0] a, input logic [1:0] sz, input logic [15:0] wd);
    logic [15:0] er; bit ee; int i; string tag;
    i = int'(a >> 2); ee = !is_legal(a, sz); er = '0;
    tag = (sz != 2'b01) ? "R3" : ee ? "R4" : (i == 2) ? "R5" :
          (i == 3 && wr) ? "R6" : (i == 4 && !wr) ? "R7" : "R2";
    if (!ee) begin
      if (wr) begin
        if (i == 2) m[2] = m[2] & ~(wd & 16'h0029);
        else m[i] = wd;
        if (i == 3 && m[0][14] && m[0][1:0] == 2'b01) m[2] = (m[2] | 16'h0020) & ~16'h0008;
      end else begin
        er = m[i];
        if (i == 4 && m[0][14] && m[0][1:0] == 2'b00) m[2] = m[2] & ~16'h0028;
      end
    end
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 0;
    check(bus_err == ee, tag, {15'h0, bus_err}, {15'h0, ee});
    check(bus_rdata == er, tag, bus_rdata, er);
    check(status_o == m[2], "R9", status_o, m[2]);
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    m[0] = 16'h0400; m[1] = 16'hFF00; m[2] = 16'h0001;
    for (int k = 3; k < 7; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(status_o == 16'h0001, "R1", status_o, 16'h0001);
    for (int k = 0; k < 7; k++) op(0, 8'(k * 4), 2'b01, 0);
    op(1, 8'h00, 2'b00, 16'h1234);   // R3 byte
    op(1, 8'h00, 2'b10, 16'h1234);   // R3 word
    op(0, 8'h00, 2'b01, 0);
    op(1, 8'h1C, 2'b01, 16'hBEEF);   // R4 past end
    op(0, 8'h02, 2'b01, 0);          // R4 misaligned
    op(1, 8'h00, 2'b01, 16'h4001);   // enable, tx-write mode
    op(1, 8'h0C, 2'b01, 16'hA5A5);   // R6 sets receive-full
    op(0, 8'h10, 2'b01, 0);          // R8 wrong mode, no clear
    op(1, 8'h08, 2'b01, 16'hFFD6);   // R5 zeros at bits 0/3/5
    op(1, 8'h00, 2'b01, 16'h4000);   // rx-read mode
    op(1, 8'h0C, 2'b01, 16'h0F0F);   // R8 no set in mode 00
    op(0, 8'h10, 2'b01, 0);          // R7 clears
    op(1, 8'h00, 2'b01, 16'h0001);   // disabled
    op(1, 8'h0C, 2'b01, 16'h1111);   // R8 disabled: no set
    op(1, 8'h00, 2'b01, 16'h4001);
    op(1, 8'h0C, 2'b01, 16'h2222);
    op(1, 8'h08, 2'b01, 16'h0020);   // R5 clear receive-full
    op(1, 8'h08, 2'b01, 16'h0001);   // R5 clear complete
    for (int n = 0; n < 800; n++) begin
      int r; logic [7:0] a; logic [1:0] sz; logic [15:0] wd;
      r = int'($urandom % 16);
      a = (r < 14) ? 8'(($urandom % 7) * 4) : 8'($urandom % 40);
      if (r < 5) a = 8'(($urandom % 2) * 12);
      sz = (($urandom % 10) == 0) ? 2'($urandom) : 2'b01;
      wd = 16'($urandom);
      if (a == 8'h00 && ($urandom % 2) == 1) wd[14] = 1'b1;
      op(($urandom % 2) == 1, a, sz, wd);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule